// File: doc/BRIEF.md
# Decimating FIR Filter with Shared Multiply-Accumulate

This block is a direct-form FIR filter that lowers the sample rate by a factor chosen at run time (2 or 4). It only computes the outputs that survive decimation, so samples that are dropped cost no arithmetic. Each output is the sum of b_k times x[n-k] for k = 0 to TAPS-1, where x[n] is the newest accepted sample. A single multiplier and accumulator are reused for every tap, so one output pass takes TAPS cycles. Typical uses are correcting the passband droop of an integrator-comb decimator (11 taps, decimate by 2 or 4) or serving as the final channel filter (41 taps, decimate by 2).

Incoming samples are written into a circular history buffer. A phase counter counts the accepted samples, and the sample that completes a group of D starts a pass. While a pass is reading the history, the input's ready signal is held low, which limits the input rate. The 24-bit coefficients are loaded through a write port. A write that arrives during a pass is held in a one-entry slot and applied once the pass has finished its reads. The accumulator carries the full product width plus guard bits. The result is rounded to nearest, with ties toward positive infinity, and then saturated to the output width.

Top module: `dfir_decim`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.
- R2: Each output equals the rounded, saturated sum of b_k·x[n−k] over k = 0..TAPS−1. Coefficient address k holds b_k. Samples older than the first one accepted after reset count as zero.
- R3: With `dec_sel` = 0, one output is produced for every 2 accepted samples: on the 2nd, 4th, 6th and so on after reset. With `dec_sel` = 1, one output is produced on every 4th accepted sample. No other outputs appear.
- R4: The full-precision sum is divided by 2^FRAC (FRAC = 23 by default) and rounded to nearest, with exact halves rounded toward positive infinity. For example, 2.5 becomes 3 and −0.5 becomes 0.
- R5: A rounded result above 2^(OW−1)−1 or below −2^(OW−1) is clamped to that limit.
- R6: After the sample that starts a pass, `in_ready` stays low for exactly TAPS cycles. Samples presented while it is low are not taken into the history.
- R7: A coefficient write made while idle is used by the next pass.
- R8: A coefficient write made during a pass does not affect that pass and is applied after it. If a second write arrives during the same pass, it replaces the first.
- R9: `out_valid` is a one-cycle pulse, and `out_data` keeps its value until the next pulse.
- R10: `out_valid` rises TAPS+3 clock edges after the edge that accepts the sample starting the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_sel | input | 1 | Decimation factor: 0 selects 2, 1 selects 4 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| in_ready | output | 1 | High when a sample can be accepted |
| cf_we | input | 1 | Coefficient write enable |
| cf_addr | input | clog2(TAPS) | Coefficient index k |
| cf_data | input | CW | Signed coefficient value |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | OW | Signed filtered output |

## Verification
The bench feeds an impulse followed by a step at both decimation factors and compares each output with an inline model. A wrong history index or a wrong phase would give shifted or extra outputs. Directed tests cover the following:
- Rounding of exact halves on both signs. A design that truncated would give 2 instead of 3 for 2.5.
- Saturation at both ends. A design that did not saturate would wrap around.
- A stray sample held on the input while `in_ready` is low. A design that took it would corrupt the next outputs.
- Two coefficient writes during one pass. Applying one of them early, or the wrong one, changes a known output from 120 to 20.
- The startup history. A design that read stale memory instead of treating it as zero would fail the impulse test.

// File: rtl/dfir_pkg.sv
package dfir_pkg;
  typedef enum logic {
    DEC_LO_SEL = 1'b0,
    DEC_HI_SEL = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/dfir_sdp_ram.sv
// Simple dual-port memory with registered read, written for block RAM inference.
module dfir_sdp_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 11,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // A write must never land while a pass is still reading this memory (R6, R8).
  assert_no_rw_clash_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
endmodule

// File: rtl/dfir_coef_hold.sv
// Routes coefficient writes; while the MAC pass is active, parks one write.
module dfir_coef_hold #(
  parameter int AW = 4,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [CW-1:0] mem_data
);
  logic          pend_v;
  logic [AW-1:0] pend_a;
  logic [CW-1:0] pend_d;

  always_comb begin
    mem_we   = !busy && (pend_v || req_we);
    mem_addr = pend_v ? pend_a : req_addr;
    mem_data = pend_v ? pend_d : req_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else if (req_we && (busy || pend_v)) begin
      pend_v <= 1'b1;
      pend_a <= req_addr;
      pend_d <= req_data;
    end else if (!busy && pend_v) begin
      pend_v <= 1'b0;
    end
  end

  // A parked write drains in the first idle cycle (R8).
  assert_hold_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !busy && !req_we) |=> !pend_v);
endmodule

// File: rtl/dfir_mac.sv
// Shared multiply-accumulate with round-half-up and saturation.
module dfir_mac #(
  parameter int DW   = 16,
  parameter int CW   = 24,
  parameter int OW   = 16,
  parameter int FRAC = 23,
  parameter int ACCW = 44
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic signed [DW-1:0] samp,
  input  logic signed [CW-1:0] coef,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int PW = DW + CW;
  localparam logic signed [ACCW:0] HALF = (ACCW+1)'(1) <<< (FRAC-1);
  localparam logic signed [ACCW:0] OMAX = ((ACCW+1)'(1) <<< (OW-1)) - 1;
  localparam logic signed [ACCW:0] OMIN = -((ACCW+1)'(1) <<< (OW-1));

  logic                   v2, first2, last2, last3;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] prod_ext;
  logic signed [ACCW:0]   rnd;
  logic signed [ACCW:0]   shifted;
  logic signed [OW-1:0]   sat_val;

  always_comb begin
    prod_ext = $signed({{(ACCW-PW){prod[PW-1]}}, prod});
    rnd      = $signed({acc[ACCW-1], acc}) + HALF;
    shifted  = rnd >>> FRAC;
    if (shifted > OMAX)      sat_val = OMAX[OW-1:0];
    else if (shifted < OMIN) sat_val = OMIN[OW-1:0];
    else                     sat_val = shifted[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2        <= 1'b0;
      first2    <= 1'b0;
      last2     <= 1'b0;
      prod      <= '0;
      acc       <= '0;
      last3     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      v2     <= in_v;
      first2 <= in_v && in_first;
      last2  <= in_v && in_last;
      if (in_v) prod <= samp * coef;
      if (v2) acc <= first2 ? prod_ext : acc + prod_ext;
      last3     <= v2 && last2;
      out_valid <= last3;
      if (last3) out_data <= sat_val;
    end
  end

  // Output strobe is a single-cycle pulse (R9).
  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

// File: rtl/dfir_decim.sv
module dfir_decim #(
  parameter int TAPS   = 11,
  parameter int DW     = 16,
  parameter int CW     = 24,
  parameter int OW     = 16,
  parameter int FRAC   = 23,
  parameter int DEC_LO = 2,
  parameter int DEC_HI = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        dec_sel,
  input  logic                        in_valid,
  input  logic signed [DW-1:0]        in_data,
  output logic                        in_ready,
  input  logic                        cf_we,
  input  logic [$clog2(TAPS)-1:0]     cf_addr,
  input  logic signed [CW-1:0]        cf_data,
  output logic                        out_valid,
  output logic signed [OW-1:0]        out_data
);
  import dfir_pkg::*;

  localparam int TAW  = $clog2(TAPS);
  localparam int FW   = $clog2(TAPS + 1);
  localparam int PHW  = (DEC_HI > 2) ? $clog2(DEC_HI) : 1;
  localparam int ACCW = DW + CW + $clog2(TAPS);
  localparam logic [TAW-1:0] LAST_TAP = TAW'(TAPS - 1);

  logic           run;
  logic [TAW-1:0] k, base, wptr;
  logic [FW-1:0]  fill;
  logic [PHW-1:0] phase, dec_last;
  logic           accept, trigger;
  logic [TAW:0]   rd_lin, rd_wrap;
  logic [TAW-1:0] rd_addr;
  logic           v1, first1, last1, mask1;
  logic [DW-1:0]  samp_rd;
  logic [CW-1:0]  coef_rd;
  logic           cm_we;
  logic [TAW-1:0] cm_addr;
  logic [CW-1:0]  cm_data;
  logic signed [DW-1:0] samp_mac;

  always_comb begin
    in_ready = !run;
    accept   = in_valid && !run;
    dec_last = (dec_mode_e'(dec_sel) == DEC_HI_SEL) ? PHW'(DEC_HI - 1) : PHW'(DEC_LO - 1);
    trigger  = accept && (phase >= dec_last);
    rd_lin   = {1'b0, base} - {1'b0, k};
    rd_wrap  = {1'b0, base} + (TAW+1)'(TAPS) - {1'b0, k};
    rd_addr  = (base >= k) ? rd_lin[TAW-1:0] : rd_wrap[TAW-1:0];
    samp_mac = mask1 ? '0 : $signed(samp_rd);
  end

  // Sequencer: history write pointer, fill level, phase and pass counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      fill  <= '0;
      phase <= '0;
      run   <= 1'b0;
      k     <= '0;
      base  <= '0;
    end else if (accept) begin
      wptr <= (wptr == LAST_TAP) ? '0 : wptr + 1'b1;
      if (int'(fill) < TAPS) fill <= fill + 1'b1;
      if (trigger) begin
        phase <= '0;
        run   <= 1'b1;
        k     <= '0;
        base  <= wptr;
      end else begin
        phase <= phase + 1'b1;
      end
    end else if (run) begin
      k <= k + 1'b1;
      if (k == LAST_TAP) run <= 1'b0;
    end
  end

  // Read-issue stage flags, aligned with the registered memory outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      first1 <= 1'b0;
      last1  <= 1'b0;
      mask1  <= 1'b0;
    end else begin
      v1     <= run;
      first1 <= run && (k == '0);
      last1  <= run && (k == LAST_TAP);
      mask1  <= int'(k) >= int'(fill);
    end
  end

  dfir_sdp_ram #(.W(DW), .DEPTH(TAPS), .AW(TAW)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (accept),
    .wr_addr (wptr),
    .wr_data (in_data),
    .rd_en   (run),
    .rd_addr (rd_addr),
    .rd_data (samp_rd)
  );

  dfir_coef_hold #(.AW(TAW), .CW(CW)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .busy     (run),
    .req_we   (cf_we),
    .req_addr (cf_addr),
    .req_data (cf_data),
    .mem_we   (cm_we),
    .mem_addr (cm_addr),
    .mem_data (cm_data)
  );

  dfir_sdp_ram #(.W(CW), .DEPTH(TAPS), .AW(TAW)) u_coef (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cm_we),
    .wr_addr (cm_addr),
    .wr_data (cm_data),
    .rd_en   (run),
    .rd_addr (k),
    .rd_data (coef_rd)
  );

  dfir_mac #(.DW(DW), .CW(CW), .OW(OW), .FRAC(FRAC), .ACCW(ACCW)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .in_v      (v1),
    .in_first  (first1),
    .in_last   (last1),
    .samp      (samp_mac),
    .coef      ($signed(coef_rd)),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // A pass only starts on an accepted input sample (R3).
  assert_pass_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(in_valid));
  // The result appears three edges after the read phase of a pass ends (R10).
  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> ##3 out_valid);
endmodule

// File: tb/dfir_decim_test.sv
module dfir_decim_test;
  localparam int TAPS = 11;
  localparam int DW   = 16;
  localparam int CW   = 24;
  localparam int OW   = 16;
  localparam int FRAC = 23;
  localparam int TAW  = $clog2(TAPS);
  localparam int NSTIM = 24;
  localparam logic signed [DW-1:0] STIM [NSTIM] = '{
    16'sd1000, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0,
    16'sd0, 16'sd0, 16'sd0, 16'sd0, -16'sd700, 16'sd500, 16'sd500, 16'sd500,
    16'sd500, 16'sd500, 16'sd500, 16'sd500, 16'sd500, 16'sd500, 16'sd500, 16'sd500};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_sel = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic in_ready;
  logic cf_we = 1'b0;
  logic [TAW-1:0] cf_addr = '0;
  logic signed [CW-1:0] cf_data = '0;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  always #10 clk = ~clk;

  dfir_decim #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW), .FRAC(FRAC)) uut (
    .clk(clk), .rst(rst), .dec_sel(dec_sel), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
    .out_valid(out_valid), .out_data(out_data));

  int total = 0;
  int bad = 0;
  longint bc [TAPS];
  longint hist [TAPS];
  int ph = 0;
  longint expq [256];
  int ewr = 0;
  int erd = 0;
  logic prev_v = 1'b0;
  longint last_out = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_out();
    longint acc = 0;
    longint r;
    for (int i = 0; i < TAPS; i++) acc += bc[i] * hist[i];
    r = (acc + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // Output monitor: values (R2), pulse shape (R9), extra outputs (R3).
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      chk(!prev_v, "R9 single-cycle pulse", 1, 0);
      if (erd >= ewr) chk(1'b0, "R3 unexpected output", longint'(out_data), 0);
      else begin
        chk(longint'(out_data) == expq[erd], "R2 output value", longint'(out_data), expq[erd]);
        erd++;
      end
      last_out = longint'(out_data);
    end
    prev_v = out_valid;
  end

  task automatic put_sample(input longint x);
    int d;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data = x[DW-1:0];
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    d = dec_sel ? 4 : 2;
    if (ph >= d - 1) begin
      ph = 0;
      expq[ewr] = ref_out();
      ewr++;
    end else ph++;
  endtask

  task automatic wr_coef(input int a, input longint v, input bit upd);
    cf_we = 1'b1;
    cf_addr = a[TAW-1:0];
    cf_data = v[CW-1:0];
    @(negedge clk);
    cf_we = 1'b0;
    if (upd) bc[a] = v;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    cf_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    ph = 0;
    erd = ewr;
  endtask

  task automatic drain();
    int w = 0;
    while (erd < ewr && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk(erd == ewr, "R3 output count", erd, ewr);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(out_data == '0, "R1 out_data after reset", longint'(out_data), 0);

    // R2/R3/R7: coefficient set loaded while idle, table walked at both factors
    for (int k = 0; k < TAPS; k++)
      wr_coef(k, (k == 3) ? -(longint'(k + 1) * 524288) : longint'(k + 1) * 524288, 1'b1);
    dec_sel = 1'b0;
    for (int i = 0; i < NSTIM; i++) put_sample(longint'(STIM[i]));
    drain();
    do_reset();
    dec_sel = 1'b1;
    for (int i = 0; i < NSTIM; i++) put_sample(longint'(STIM[i]));
    drain();

    // R6 / R10: ready window, stray samples, latency
    begin
      int lowc;
      int hit;
      do_reset();
      dec_sel = 1'b0;
      put_sample(11);
      put_sample(22);
      chk(!in_ready, "R6 ready low after trigger", in_ready, 0);
      lowc = 1;
      hit = -1;
      for (int c = 1; c <= 30; c++) begin
        if (c <= 4) begin
          in_valid = 1'b1;
          in_data = 16'sd9999;
        end else in_valid = 1'b0;
        @(negedge clk);
        if (!in_ready) lowc++;
        if (out_valid && hit < 0) hit = c;
      end
      in_valid = 1'b0;
      chk(lowc == TAPS, "R6 ready-low cycles", lowc, TAPS);
      chk(hit == TAPS + 3, "R10 output latency", hit, TAPS + 3);
      put_sample(33);
      put_sample(44);
      drain();
      // R9: data held while no strobe
      chk(longint'(out_data) == last_out, "R9 data held", longint'(out_data), last_out);
    end

    // R4: rounding with b0 = 0.5
    do_reset();
    for (int k = 0; k < TAPS; k++) wr_coef(k, (k == 0) ? longint'(4194304) : 0, 1'b1);
    dec_sel = 1'b0;
    put_sample(0); put_sample(1);
    put_sample(0); put_sample(-1);
    drain();
    chk(last_out == 0, "R4 -0.5 rounds to 0", last_out, 0);
    put_sample(0); put_sample(-3);
    drain();
    chk(last_out == -1, "R4 -1.5 rounds to -1", last_out, -1);
    put_sample(0); put_sample(5);
    drain();
    chk(last_out == 3, "R4 2.5 rounds to 3", last_out, 3);

    // R5: saturation at both ends
    do_reset();
    for (int k = 0; k < TAPS; k++) wr_coef(k, 8388607, 1'b1);
    for (int i = 0; i < 4; i++) put_sample(32767);
    drain();
    chk(last_out == 32767, "R5 positive clamp", last_out, 32767);
    for (int i = 0; i < 12; i++) put_sample(-32768);
    drain();
    chk(last_out == -32768, "R5 negative clamp", last_out, -32768);

    // R8: writes during a pass are held; the later one wins
    do_reset();
    for (int k = 0; k < TAPS; k++) wr_coef(k, (k == 0) ? longint'(4194304) : 0, 1'b1);
    put_sample(0);
    put_sample(100);
    wr_coef(0, 0, 1'b0);
    wr_coef(1, 4194304, 1'b0);
    bc[1] = 4194304;
    drain();
    chk(last_out == 50, "R8 pass unaffected by held write", last_out, 50);
    put_sample(40);
    put_sample(200);
    drain();
    chk(last_out == 120, "R8 held write applied, second replaces first", last_out, 120);

    // R7: idle write used by the next pass
    wr_coef(0, 0, 1'b1);
    put_sample(7);
    put_sample(9);
    drain();
    chk(last_out == 4, "R7 idle write takes effect", last_out, 4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule